// File: doc/BRIEF.md
# SHA-512 Message Schedule Helper

This unit performs the two partial updates that build the SHA-512 message schedule four 64-bit words at a time. A request carries an operation select, a 256-bit working operand split into four 64-bit lanes (lane 0 in bits 63:0, lane 3 in bits 255:192), and a 256-bit source operand. The unit adds a small-sigma term to each lane and returns the updated 256-bit operand from a result register one clock later.

The first operation adds small sigma-0 terms taken from the next lane up, with the top lane drawing on the lowest source word. The second operation adds small sigma-1 terms. Its two low lanes use the upper source words, and its two high lanes use the freshly updated low lanes of the same result. One request can be accepted on every cycle.

Top module: `sha512_sched_unit`

## Requirements
- R1: Small sigma-0 of a word x is (x rotated right by 1) XOR (x rotated right by 8) XOR (x shifted right logically by 7).
- R2: Small sigma-1 of a word x is (x rotated right by 19) XOR (x rotated right by 61) XOR (x shifted right logically by 6).
- R3: With in_op = 0, result lanes 0, 1 and 2 are the working lanes 0, 1 and 2 plus sigma-0 of working lanes 1, 2 and 3 respectively.
- R4: With in_op = 0, result lane 3 is working lane 3 plus sigma-0 of source bits 63:0.
- R5: With in_op = 0, source bits 255:64 have no effect on the result.
- R6: With in_op = 1, result lanes 0 and 1 are working lanes 0 and 1 plus sigma-1 of source lanes 2 and 3 (bits 191:128 and 255:192) respectively.
- R7: With in_op = 1, result lanes 2 and 3 are working lanes 2 and 3 plus sigma-1 of the updated result lanes 0 and 1, not the original working lanes.
- R8: Every lane sum wraps modulo 2^64, and no carry passes from one lane into the next.
- R9: out_valid is high in exactly the cycle after a cycle with in_valid high, and out_data then holds that request's result. Back-to-back requests give back-to-back results.
- R10: While no request is accepted, out_data keeps its last value.
- R11: A synchronous active-high rst clears out_valid and out_data to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request accepted this cycle |
| in_op | input | 1 | 0: sigma-0 update, 1: sigma-1 update |
| in_dst | input | 256 | Working operand, lanes 0..3 |
| in_src | input | 256 | Source operand |
| out_valid | output | 1 | Result strobe, one cycle after acceptance |
| out_data | output | 256 | Updated operand |

## Verification
There is only one state element: the result register and its strobe. A wrong value there shows on out_data in the cycle after acceptance, or in a later idle cycle if the register fails to hold. The bench model recomputes each lane from the requirements and compares every cycle. A broken lane chain in the second operation shows only in lanes 2 and 3, so those lanes are compared on their own with random and all-ones operands. All-ones operands also expose carries that cross lane boundaries.

// File: rtl/sha512_sched_unit.sv
module sha512_sched_unit #(
  parameter int WORD_W = 64,
  parameter int LANES  = 4,
  localparam int BUS_W = WORD_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_op,
  input  logic [BUS_W-1:0] in_dst,
  input  logic [BUS_W-1:0] in_src,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_data
);

  function automatic logic [WORD_W-1:0] rotr(input logic [WORD_W-1:0] x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] sig_lo(input logic [WORD_W-1:0] x);
    return rotr(x, 1) ^ rotr(x, 8) ^ (x >> 7);
  endfunction

  function automatic logic [WORD_W-1:0] sig_hi(input logic [WORD_W-1:0] x);
    return rotr(x, 19) ^ rotr(x, 61) ^ (x >> 6);
  endfunction

  logic [WORD_W-1:0] d [LANES];
  logic [WORD_W-1:0] s [LANES];
  logic [WORD_W-1:0] r0 [LANES];
  logic [WORD_W-1:0] r1 [LANES];
  logic [BUS_W-1:0]  nxt;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign d[g] = in_dst[g*WORD_W +: WORD_W];
      assign s[g] = in_src[g*WORD_W +: WORD_W];
      if (g < LANES - 1) begin : g_lo
        assign r0[g] = d[g] + sig_lo(d[g+1]);
      end else begin : g_top
        assign r0[g] = d[g] + sig_lo(s[0]);
      end
      if (g < 2) begin : g_src
        assign r1[g] = d[g] + sig_hi(s[g+2]);
      end else begin : g_chain
        assign r1[g] = d[g] + sig_hi(r1[g-2]);
      end
      assign nxt[g*WORD_W +: WORD_W] = in_op ? r1[g] : r0[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= nxt;
    end
  end

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_data));
  a_r11_reset: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));
  a_r7_chain: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op) |=>
      out_data[2*WORD_W +: WORD_W] == $past(in_dst[2*WORD_W +: WORD_W]) + sig_hi(out_data[0 +: WORD_W]));
  a_r5_upper_ignored: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_op) |=>
      out_data[3*WORD_W +: WORD_W] == $past(in_dst[3*WORD_W +: WORD_W]) + sig_lo($past(in_src[0 +: WORD_W])));

endmodule

// File: tb/sha512_sched_unit_tb.sv
module sha512_sched_unit_tb_top;
  logic         clk = 0;
  logic         rst;
  logic         in_valid;
  logic         in_op;
  logic [255:0] in_dst;
  logic [255:0] in_src;
  logic         out_valid;
  logic [255:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic         exp_valid;
  logic [255:0] exp_data;

  always #5ns clk = ~clk;

  sha512_sched_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src(in_src), .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [63:0] rr(logic [63:0] x, int n);
    logic [63:0] y = x;
    for (int i = 0; i < n; i++) y = {y[0], y[63:1]};
    return y;
  endfunction
  function automatic logic [63:0] m_s0(logic [63:0] x);
    return rr(x, 1) ^ rr(x, 8) ^ (x >> 7);
  endfunction
  function automatic logic [63:0] m_s1(logic [63:0] x);
    return rr(x, 19) ^ rr(x, 61) ^ (x >> 6);
  endfunction

  function automatic logic [255:0] model(logic op, logic [255:0] dv, logic [255:0] sv);
    logic [63:0] w [4];
    logic [63:0] a [4];
    logic [255:0] res;
    for (int i = 0; i < 4; i++) begin
      w[i] = dv[i*64 +: 64];
      a[i] = sv[i*64 +: 64];
    end
    if (!op) begin
      w[0] = w[0] + m_s0(w[1]);
      w[1] = w[1] + m_s0(w[2]);
      w[2] = w[2] + m_s0(w[3]);
      w[3] = w[3] + m_s0(a[0]);
    end else begin
      w[0] = w[0] + m_s1(a[2]);
      w[1] = w[1] + m_s1(a[3]);
      w[2] = w[2] + m_s1(w[0]);
      w[3] = w[3] + m_s1(w[1]);
    end
    for (int i = 0; i < 4; i++) res[i*64 +: 64] = w[i];
    return res;
  endfunction

  task automatic check(string tag);
    checks++;
    if (out_valid !== exp_valid) begin
      errors++;
      $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, exp_valid);
    end
    checks++;
    if (out_data !== exp_data) begin
      errors++;
      $display("FAIL %s out_data actual %h expected %h", tag, out_data, exp_data);
    end
  endtask

  task automatic step(logic r, logic v, logic op, logic [255:0] dv, logic [255:0] sv, string tag);
    @(negedge clk);
    rst = r; in_valid = v; in_op = op; in_dst = dv; in_src = sv;
    if (r) begin exp_valid = 0; exp_data = '0; end
    else begin
      exp_valid = v;
      if (v) exp_data = model(op, dv, sv);
    end
    @(posedge clk);
    #2ns;
    check(tag);
  endtask

  function automatic logic [255:0] rnd256();
    return {$urandom(), $urandom(), $urandom(), $urandom(),
            $urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2ms;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [255:0] dv, sv, base;
    rst = 1; in_valid = 0; in_op = 0; in_dst = '0; in_src = '0;
    exp_valid = 0; exp_data = '0;
    step(1, 0, 0, '0, '0, "R11 reset");
    step(1, 1, 1, '1, '1, "R11 reset ignores request");

    // R1 R3 R4: single-bit lanes expose each rotation and shift
    dv = {64'h0, 64'h0, 64'h8000_0000_0000_0000, 64'h0};
    step(0, 1, 0, dv, {192'h0, 64'h1}, "R1 R3 R4 sigma0 bits");
    // R2 R6 R7
    step(0, 1, 1, '0, {64'h1, 64'h8000_0000_0000_0001, 128'h0}, "R2 R6 R7 sigma1 bits");

    // R5: garbage upper source must match zero upper source
    dv = rnd256(); sv = rnd256();
    step(0, 1, 0, dv, {192'h0, sv[63:0]}, "R5 zero upper");
    base = out_data;
    step(0, 1, 0, dv, sv, "R5 random upper");
    checks++;
    if (out_data !== base) begin
      errors++;
      $display("FAIL R5 actual %h expected %h", out_data, base);
    end

    // R8: all-ones lanes, wrap without inter-lane carry
    step(0, 1, 0, '1, '1, "R8 wrap op0");
    step(0, 1, 1, '1, '1, "R8 wrap op1");
    step(0, 1, 1, {4{64'hFFFF_FFFF_FFFF_FFFF}}, {4{64'h0123_4567_89AB_CDEF}}, "R8 R7 wrap chain");

    // R10: idle cycles keep last result
    step(0, 0, 1, rnd256(), rnd256(), "R10 idle 1");
    step(0, 0, 0, rnd256(), rnd256(), "R10 idle 2");

    // R9: back-to-back mixed random traffic with gaps
    for (int k = 0; k < 400; k++) begin
      logic v = ($urandom_range(0, 3) != 0);
      step(0, v, $urandom_range(0, 1), rnd256(), rnd256(), "R9 R3 R6 R7 random");
    end

    // R11 mid-run reset
    step(0, 1, 1, rnd256(), rnd256(), "R9 before reset");
    step(1, 1, 0, rnd256(), rnd256(), "R11 mid reset");
    step(0, 1, 0, rnd256(), rnd256(), "R9 after reset");

    finish_run();
  end
endmodule